// File: doc/BRIEF.md
# Privilege and Illegal-Instruction Trap Entry

This block sits at the retire point of a processor and makes the final decision for each decoded instruction. It either lets the instruction execute, stops the core, or sends it to the program-check trap. It takes the operation class from the decoder, the top bit of the instruction's special-register number, the decoder's illegal flag, the current instruction address and the machine state register. It does not look at the raw instruction word.

On a trap it stores the faulting address and a tagged copy of the state register in two save/restore registers. It then rewrites the live state register to a fixed supervisor pattern and redirects the next address to the fixed vector 0x700. A halt instruction issued in supervisor state sets a sticky halted flag. After that, every later instruction is ignored until reset. All outputs are registered, so the result of an instruction issued in cycle N appears after the clock edge that ends cycle N.

Top module: `trap_entry_unit`

## Requirements
- R1: While reset is high at a clock edge, all outputs clear: next address 0, state 0, both save registers 0, halted 0, trap pulse 0. Only reset clears the halted flag.
- R2: Operation class codes on `op_i` are: 0 plain, 1 halt, 2 read-state, 3 write-state, 4 write-state-doubleword, 5 return-from-interrupt, 6 read-special-register, 7 write-special-register, 8 write-condition-field. Codes 1 to 5 are always privileged.
- R3: Codes 6 and 7 are privileged only when `spr_hi_i` is 1. With `spr_hi_i` at 0 they execute normally even in problem state.
- R4: A privileged operation issued while state bit 14 (problem state) is 1 traps. Next address becomes 0x700, save register 0 gets the instruction address, and save register 1 gets the incoming state with bit 18 (privilege cause) set. This check wins over the illegal check.
- R5: A non-privileged-trapping instruction with `illegal_i` set traps the same way, but with bit 19 (illegal cause) set in save register 1. Code 8 never takes this trap.
- R6: On any trap the new state has these bits at 0: 58, 32, 25, 23, 15, 14, 13, 11, 10, 9, 8, 5, 4, 2, 1. The clear mask is 0x0400_0001_0280_EF36.
- R7: On any trap the new state has bits 63 (64-bit mode) and 0 (little-endian) at 1. All other bits keep their incoming values.
- R8: A halt operation issued with bit 14 at 0 sets the sticky halted flag. The next address holds that instruction's address and the state passes through unchanged. From then on no instruction changes any output until reset.
- R9: A halt operation issued with bit 14 at 1 takes the privilege trap and does not halt.
- R10: An instruction that neither traps nor halts sets the next address to its address plus 4 and passes the state through. It leaves both save registers unchanged.
- R11: `trap_o` is 1 for exactly the one cycle after a trapping instruction and 0 otherwise.
- R12: A cycle with `valid_i` at 0 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| op_i | input | 4 | Operation class code (R2) |
| spr_hi_i | input | 1 | Top bit of the special-register number |
| illegal_i | input | 1 | Decoder flagged the instruction as illegal |
| cia_i | input | 64 | Current instruction address |
| msr_i | input | 64 | Current machine state register |
| nia_o | output | 64 | Next instruction address |
| msr_o | output | 64 | New machine state register |
| srr0_o | output | 64 | Save/restore register 0 (return address) |
| srr1_o | output | 64 | Save/restore register 1 (saved state plus cause) |
| halted_o | output | 1 | Sticky halted flag |
| trap_o | output | 1 | One-cycle trap-entry pulse |

## Verification
The bench targets the orderings that are easy to get wrong. A halt in problem state must trap rather than stop the core, or the user code would freeze the machine. An illegal privileged instruction must report the privilege cause, not the illegal one. Write-condition-field instructions must slip past the illegal check, and a design that forgot this would trap on valid code. The special-register ops are tried with the top number bit both set and clear, to catch a design that traps on every special-register access. A state pattern with ones spread across all bits shows whether the cause bit leaks into the live state and whether the rewrite touches any bit outside its mask. After a halt, illegal and privileged instructions are both issued to prove the flag really freezes all state. Reset is then shown to be the only way out.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int XLEN = 64;
    typedef logic [XLEN-1:0] word_t;

    // State-register bit positions (LSB = 0)
    localparam int MB_SIXTY_FOUR = 63;
    localparam int MB_UNDEF      = 58;
    localparam int MB_TXN        = 32;
    localparam int MB_VECTOR     = 25;
    localparam int MB_VSX        = 23;
    localparam int MB_EXT_EN     = 15;
    localparam int MB_PROBLEM    = 14;
    localparam int MB_FP_AVAIL   = 13;
    localparam int MB_FPX_MODE0  = 11;
    localparam int MB_STEP_TRACE = 10;
    localparam int MB_BR_TRACE   = 9;
    localparam int MB_FPX_MODE1  = 8;
    localparam int MB_RELOC_I    = 5;
    localparam int MB_RELOC_D    = 4;
    localparam int MB_PERF_MARK  = 2;
    localparam int MB_RECOVER    = 1;
    localparam int MB_LITTLE     = 0;

    // Cause bits recorded in the saved copy
    localparam int CAUSE_PRIV = 18;
    localparam int CAUSE_ILL  = 19;

    typedef enum logic [3:0] {
        OPC_PLAIN     = 4'd0,
        OPC_HALT      = 4'd1,
        OPC_RD_STATE  = 4'd2,
        OPC_WR_STATE  = 4'd3,
        OPC_WR_STATED = 4'd4,
        OPC_RET_INT   = 4'd5,
        OPC_RD_SPR    = 4'd6,
        OPC_WR_SPR    = 4'd7,
        OPC_WR_CRF    = 4'd8
    } opclass_e;

    typedef enum logic [1:0] {
        ACT_RUN       = 2'd0,
        ACT_HALT      = 2'd1,
        ACT_TRAP_PRIV = 2'd2,
        ACT_TRAP_ILL  = 2'd3
    } action_e;

    typedef struct packed {
        word_t nia;
        word_t msr;
        word_t srr0;
        word_t srr1;
        logic  halted;
        logic  trap;
    } arch_state_t;

    function automatic word_t trap_clear_mask();
        word_t m;
        m = '0;
        m[MB_UNDEF]      = 1'b1;
        m[MB_TXN]        = 1'b1;
        m[MB_VECTOR]     = 1'b1;
        m[MB_VSX]        = 1'b1;
        m[MB_EXT_EN]     = 1'b1;
        m[MB_PROBLEM]    = 1'b1;
        m[MB_FP_AVAIL]   = 1'b1;
        m[MB_FPX_MODE0]  = 1'b1;
        m[MB_STEP_TRACE] = 1'b1;
        m[MB_BR_TRACE]   = 1'b1;
        m[MB_FPX_MODE1]  = 1'b1;
        m[MB_RELOC_I]    = 1'b1;
        m[MB_RELOC_D]    = 1'b1;
        m[MB_PERF_MARK]  = 1'b1;
        m[MB_RECOVER]    = 1'b1;
        return m;
    endfunction

    function automatic word_t trap_set_mask();
        word_t m;
        m = '0;
        m[MB_SIXTY_FOUR] = 1'b1;
        m[MB_LITTLE]     = 1'b1;
        return m;
    endfunction

    function automatic logic is_always_priv(opclass_e op);
        return (op == OPC_HALT) || (op == OPC_RD_STATE) || (op == OPC_WR_STATE) ||
               (op == OPC_WR_STATED) || (op == OPC_RET_INT);
    endfunction

endpackage

// File: rtl/trap_classify.sv
module trap_classify
    import trap_pkg::*;
(
    input  opclass_e op_i,
    input  logic     spr_hi_i,
    input  logic     illegal_i,
    input  logic     problem_i,
    output action_e  act_o
);
    logic privileged;
    logic spr_priv;

    always_comb begin
        spr_priv   = ((op_i == OPC_RD_SPR) || (op_i == OPC_WR_SPR)) && spr_hi_i;
        privileged = is_always_priv(op_i) || spr_priv;
        // Order: privilege, then halt, then illegal
        if (privileged && problem_i)
            act_o = ACT_TRAP_PRIV;
        else if (op_i == OPC_HALT)
            act_o = ACT_HALT;
        else if (illegal_i && (op_i != OPC_WR_CRF))
            act_o = ACT_TRAP_ILL;
        else
            act_o = ACT_RUN;
    end
endmodule

// File: rtl/trap_msr_shaper.sv
module trap_msr_shaper
    import trap_pkg::*;
(
    input  action_e act_i,
    input  word_t   msr_i,
    output word_t   msr_trap_o,
    output word_t   srr1_o
);
    localparam word_t CLR = trap_clear_mask();
    localparam word_t SET = trap_set_mask();

    always_comb begin
        msr_trap_o = (msr_i & ~CLR) | SET;
        srr1_o     = msr_i;
        if (act_i == ACT_TRAP_PRIV)
            srr1_o[CAUSE_PRIV] = 1'b1;
        if (act_i == ACT_TRAP_ILL)
            srr1_o[CAUSE_ILL] = 1'b1;
    end
endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs
    import trap_pkg::*;
#(
    parameter word_t       TRAP_VEC   = 64'h700,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_i,
    input  action_e     act_i,
    input  word_t       cia_i,
    input  word_t       msr_i,
    input  word_t       msr_trap_i,
    input  word_t       srr1_new_i,
    output arch_state_t st_o
);
    localparam word_t STEP = word_t'(INSN_BYTES);

    arch_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.trap <= 1'b0;
            if (valid_i && !st_q.halted) begin
                unique case (act_i)
                    ACT_RUN: begin
                        st_q.nia <= cia_i + STEP;
                        st_q.msr <= msr_i;
                    end
                    ACT_HALT: begin
                        st_q.halted <= 1'b1;
                        st_q.nia    <= cia_i;
                        st_q.msr    <= msr_i;
                    end
                    default: begin
                        st_q.nia  <= TRAP_VEC;
                        st_q.msr  <= msr_trap_i;
                        st_q.srr0 <= cia_i;
                        st_q.srr1 <= srr1_new_i;
                        st_q.trap <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign st_o = st_q;
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter logic [63:0] TRAP_VEC   = 64'h700,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_i,
    input  logic [3:0]  op_i,
    input  logic        spr_hi_i,
    input  logic        illegal_i,
    input  logic [63:0] cia_i,
    input  logic [63:0] msr_i,
    output logic [63:0] nia_o,
    output logic [63:0] msr_o,
    output logic [63:0] srr0_o,
    output logic [63:0] srr1_o,
    output logic        halted_o,
    output logic        trap_o
);
    action_e     act;
    word_t       msr_trap;
    word_t       srr1_new;
    arch_state_t st;

    trap_classify u_cls (
        .op_i      (opclass_e'(op_i)),
        .spr_hi_i  (spr_hi_i),
        .illegal_i (illegal_i),
        .problem_i (msr_i[MB_PROBLEM]),
        .act_o     (act)
    );

    trap_msr_shaper u_shp (
        .act_i      (act),
        .msr_i      (msr_i),
        .msr_trap_o (msr_trap),
        .srr1_o     (srr1_new)
    );

    trap_state_regs #(
        .TRAP_VEC   (TRAP_VEC),
        .INSN_BYTES (INSN_BYTES)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .valid_i    (valid_i),
        .act_i      (act),
        .cia_i      (cia_i),
        .msr_i      (msr_i),
        .msr_trap_i (msr_trap),
        .srr1_new_i (srr1_new),
        .st_o       (st)
    );

    assign nia_o    = st.nia;
    assign msr_o    = st.msr;
    assign srr0_o   = st.srr0;
    assign srr1_o   = st.srr1;
    assign halted_o = st.halted;
    assign trap_o   = st.trap;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
    import trap_pkg::*;
#(
    parameter logic [63:0] TRAP_VEC   = 64'h700,
    parameter int unsigned INSN_BYTES = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        valid_i,
    input logic [3:0]  op_i,
    input logic        spr_hi_i,
    input logic        illegal_i,
    input logic [63:0] cia_i,
    input logic [63:0] msr_i,
    input logic [63:0] nia_o,
    input logic [63:0] msr_o,
    input logic [63:0] srr0_o,
    input logic [63:0] srr1_o,
    input logic        halted_o,
    input logic        trap_o
);
    localparam logic [63:0] STEP = 64'(INSN_BYTES);
    localparam logic [63:0] CLR  = trap_clear_mask();

    p_trap_vector_r4: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> (nia_o == TRAP_VEC));

    p_rd_state_trap_r4: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !halted_o && msr_i[MB_PROBLEM] && op_i == 4'd2)
        |=> (trap_o && srr0_o == $past(cia_i) && srr1_o[CAUSE_PRIV]));

    p_spr_low_runs_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !halted_o && op_i == 4'd6 && !spr_hi_i && !illegal_i)
        |=> (!trap_o && nia_o == $past(cia_i) + STEP));

    p_trap_cleared_r6: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> ((msr_o & CLR) == 64'd0));

    p_trap_modes_r7: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> (msr_o[MB_SIXTY_FOUR] && msr_o[MB_LITTLE]));

    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        halted_o |=> (halted_o && $stable(nia_o) && $stable(msr_o) &&
                      $stable(srr0_o) && $stable(srr1_o) && !trap_o));

    p_halt_priv_first_r9: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !halted_o && op_i == 4'd1 && msr_i[MB_PROBLEM])
        |=> (trap_o && !halted_o));

    p_plain_step_r10: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !halted_o && op_i == 4'd0 && !illegal_i)
        |=> (nia_o == $past(cia_i) + STEP && msr_o == $past(msr_i) && !trap_o));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(nia_o) && $stable(msr_o) && $stable(srr0_o) &&
                      $stable(srr1_o) && !trap_o));
endmodule

bind trap_entry_unit trap_entry_chk #(
    .TRAP_VEC   (TRAP_VEC),
    .INSN_BYTES (INSN_BYTES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .op_i      (op_i),
    .spr_hi_i  (spr_hi_i),
    .illegal_i (illegal_i),
    .cia_i     (cia_i),
    .msr_i     (msr_i),
    .nia_o     (nia_o),
    .msr_o     (msr_o),
    .srr0_o    (srr0_o),
    .srr1_o    (srr1_o),
    .halted_o  (halted_o),
    .trap_o    (trap_o)
);

// File: tb/sim_trap_entry_unit.sv
`timescale 1ns/1ps
module sim_trap_entry_unit;

    localparam logic [63:0] CLR  = 64'h0400_0001_0280_EF36;
    localparam logic [63:0] SETM = 64'h8000_0000_0000_0001;
    localparam logic [63:0] PR   = 64'h0000_0000_0000_4000;

    typedef struct packed {
        logic [63:0] nia, msr, s0, s1;
        logic        h, t;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic        spr_hi_i = 1'b0;
    logic        illegal_i = 1'b0;
    logic [63:0] cia_i = '0;
    logic [63:0] msr_i = '0;
    logic [63:0] nia_o, msr_o, srr0_o, srr1_o;
    logic        halted_o, trap_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    exp_t  q[$];
    string rq[$];

    logic [63:0] m_nia, m_msr, m_s0, m_s1;
    logic        m_h, m_t;

    always #4 clk = ~clk;

    trap_entry_unit u0 (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
        .spr_hi_i(spr_hi_i), .illegal_i(illegal_i), .cia_i(cia_i), .msr_i(msr_i),
        .nia_o(nia_o), .msr_o(msr_o), .srr0_o(srr0_o), .srr1_o(srr1_o),
        .halted_o(halted_o), .trap_o(trap_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_trap(input logic [63:0] cia, input logic [63:0] msr, input int cause);
        m_s0  = cia;
        m_s1  = msr | (64'd1 << cause);
        m_msr = (msr & ~CLR) | SETM;
        m_nia = 64'h700;
        m_t   = 1'b1;
    endtask

    // Driver: applies one cycle of stimulus and queues the expected outputs
    task automatic drive(input logic v, input logic [3:0] op, input logic hi,
                         input logic ill, input logic [63:0] cia,
                         input logic [63:0] msr, input string req);
        logic priv;
        @(negedge clk);
        valid_i = v; op_i = op; spr_hi_i = hi; illegal_i = ill;
        cia_i = cia; msr_i = msr;
        m_t = 1'b0;
        if (v && !m_h) begin
            priv = (op >= 4'd1 && op <= 4'd5) || ((op == 4'd6 || op == 4'd7) && hi);
            if (priv && msr[14])            model_trap(cia, msr, 18);
            else if (op == 4'd1)            begin m_h = 1'b1; m_nia = cia; m_msr = msr; end
            else if (ill && op != 4'd8)     model_trap(cia, msr, 19);
            else                            begin m_nia = cia + 64'd4; m_msr = msr; end
        end
        q.push_back('{nia: m_nia, msr: m_msr, s0: m_s0, s1: m_s1, h: m_h, t: m_t});
        rq.push_back(req);
    endtask

    // Monitor: compares each queued item after the edge that produces it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t  e;
                string r;
                e = q.pop_front();
                r = rq.pop_front();
                chk(r, "nia",    nia_o,           e.nia);
                chk(r, "msr",    msr_o,           e.msr);
                chk(r, "srr0",   srr0_o,          e.s0);
                chk(r, "srr1",   srr1_o,          e.s1);
                chk(r, "halted", {63'd0, halted_o}, {63'd0, e.h});
                chk("R11", "trap", {63'd0, trap_o}, {63'd0, e.t});
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; valid_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset nia",    nia_o,  64'd0);
        chk("R1", "reset msr",    msr_o,  64'd0);
        chk("R1", "reset srr0",   srr0_o, 64'd0);
        chk("R1", "reset srr1",   srr1_o, 64'd0);
        chk("R1", "reset halted", {63'd0, halted_o}, 64'd0);
        chk("R1", "reset trap",   {63'd0, trap_o},   64'd0);
        rst = 1'b0;
        m_nia = '0; m_msr = '0; m_s0 = '0; m_s1 = '0; m_h = 1'b0; m_t = 1'b0;
    endtask

    initial begin
        logic [63:0] pat;
        pat = 64'h0123_4567_89AB_CDEF;
        do_reset();

        drive(1, 4'd0, 0, 0, 64'h1000, 64'h0, "R10");
        drive(1, 4'd0, 0, 0, 64'h1004, pat & ~PR, "R10");
        drive(0, 4'd0, 0, 1, 64'h9999, 64'hFFFF, "R12");
        drive(0, 4'd2, 1, 1, 64'h7777, PR, "R12");
        drive(1, 4'd6, 0, 0, 64'h2000, pat | PR, "R3");
        drive(1, 4'd7, 0, 0, 64'h2004, pat | PR, "R3");
        drive(1, 4'd7, 1, 0, 64'h2008, pat | PR, "R3");
        drive(1, 4'd0, 0, 0, 64'h700, 64'h0, "R11");
        drive(1, 4'd6, 1, 0, 64'h200C, ~64'd0, "R6");
        drive(1, 4'd2, 0, 0, 64'h3000, pat & ~PR, "R2");
        for (int k = 1; k <= 5; k++)
            drive(1, 4'(k), 0, 0, 64'h4000 + 64'(k * 4), pat | PR, "R2");
        drive(1, 4'd0, 0, 1, 64'h5000, pat & ~PR, "R5");
        drive(1, 4'd8, 0, 1, 64'h5004, pat & ~PR, "R5");
        drive(1, 4'd8, 0, 1, 64'h5008, pat | PR, "R5");
        drive(1, 4'd3, 0, 1, 64'h5010, pat | PR, "R4");
        drive(1, 4'd0, 0, 1, 64'h5014, 64'h0, "R7");
        drive(1, 4'd1, 0, 0, 64'h6000, PR, "R9");
        drive(1, 4'd1, 0, 0, 64'h6100, pat & ~PR, "R8");
        drive(1, 4'd0, 0, 0, 64'h6104, 64'h0, "R8");
        drive(1, 4'd0, 0, 1, 64'h6108, 64'h0, "R8");
        drive(1, 4'd3, 0, 0, 64'h610C, PR, "R8");
        drive(0, 4'd0, 0, 0, 64'h0, 64'h0, "R8");
        @(negedge clk);
        @(negedge clk);

        do_reset();
        drive(1, 4'd0, 0, 0, 64'h8000, 64'h0, "R1");
        @(negedge clk);
        @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule